// File: doc/BRIEF.md
# Serial SAR ADC digital core

This block is the digital control side of a two-input, 8-bit successive-approximation converter with a serial link. A host pulls chip select low and clocks the serial clock. On the data input it sends a start bit and then a two-bit input assignment. The core drives the analog multiplexer selection from that word and gives the inputs one clock to settle. It then runs an eight-step binary search against an external comparator through a trial code for the resistor ladder. Each decided bit goes out on the serial output as soon as it is known.

After the MSB-first stream, the core repeats the result in the opposite order and does not resend bit 0. The serial output is driven only while result or settling data is on it, and no address bit is read while it is driven. The data line and the output line can therefore share one wire. Raising chip select ends any frame at once and clears all state.

Top module: `sadc_core`

## Requirements
- R1: While `cs_n` is high, all state is held clear: `do_oe`=0, `trial_code`=0, `sel_single`=0, `sel_odd`=0. A rise of `cs_n` in the middle of a frame clears them without waiting for a clock.
- R2: After `cs_n` falls, zeros on `di` at rising `sclk` edges are skipped. The first 1 is taken as the start bit.
- R3: The two `di` bits after the start bit are captured in order: first the mode bit (1 = single-ended, shown on `sel_single`), then the select bit (shown on `sel_odd`). In single-ended mode `sel_odd`=1 picks input 1 and `sel_odd`=0 picks input 0. In differential mode `sel_odd`=0 makes input 0 positive and input 1 negative, and `sel_odd`=1 swaps them.
- R4: For the one clock after the select bit is captured, `do_oe`=1 and `do_data`=0.
- R5: During search step k (k = 7 down to 0), `trial_code` keeps the decided bits above k, sets bit k and clears the bits below k. `trial_code` is 0 outside the search. Bit k is kept at 1 when `cmp_gt`=1, meaning the input is at or above the ladder.
- R6: On the eight clocks after settling, `do_data` carries result bits 7 down to 0, one bit per clock.
- R7: On the next seven clocks, `do_data` carries result bits 1 up to 7.
- R8: `di` has no effect from the start bit's capture until `cs_n` rises. The selection and the result do not change.
- R9: After the last LSB-first bit, `do_oe` returns to 0 and stays 0 for any further clocks while `cs_n` stays low.
- R10: When the positive input is below the negative input, every comparator decision is 0 and the result is 0x00.
- R11: A new conversion needs `cs_n` to go high and then low again, followed by a new start bit and assignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. All state changes on its rising edge. |
| cs_n | input | 1 | Active-low chip select. A high level is an asynchronous clear. |
| di | input | 1 | Serial data in: start bit and assignment bits. |
| cmp_gt | input | 1 | Comparator result: 1 when the selected input is at or above the ladder level. |
| trial_code | output | 8 | Ladder trial code. |
| sel_single | output | 1 | 1 = single-ended, 0 = differential. |
| sel_odd | output | 1 | Channel or polarity select, as defined in R3. |
| do_data | output | 1 | Serial data out value. |
| do_oe | output | 1 | Output enable for the serial data out. |

## Verification
Two functions share cycles here. During each MSB-first step, the bit being decided goes out on `do_data` in the same cycle that `trial_code` probes it. During the whole conversion, `di` can also be toggling while it must be ignored. The bench provokes both: it feeds a run of ones and toggling bits on `di` through the settle, search and reverse phases. It also places analog values so that the comparator flips on different bits. Each cycle, a behavioural model compares the driven bit, the trial code and the selection outputs against values computed from the channel voltages alone.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    PH_WAIT   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_SETTLE = 3'd2,
    PH_MSB    = 3'd3,
    PH_LSB    = 3'd4,
    PH_DONE   = 3'd5
  } phase_t;
endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int RES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     di,
  output phase_t                   phase,
  output logic [$clog2(RES)-1:0]   idx,
  output logic                     cfg_sgl,
  output logic                     cfg_odd
);
  localparam int IDXW = $clog2(RES);
  localparam logic [IDXW-1:0] TOP = IDXW'(RES - 1);

  phase_t          phase_nx;
  logic [IDXW-1:0] idx_nx;
  logic            sgl_en, odd_en;

  always_comb begin
    phase_nx = phase;
    idx_nx   = idx;
    sgl_en   = 1'b0;
    odd_en   = 1'b0;
    unique case (phase)
      PH_WAIT: if (di) begin
        phase_nx = PH_ADDR;
        idx_nx   = '0;
      end
      PH_ADDR: begin
        if (idx == '0) begin
          sgl_en = 1'b1;
          idx_nx = IDXW'(1);
        end else begin
          odd_en   = 1'b1;
          phase_nx = PH_SETTLE;
        end
      end
      PH_SETTLE: begin
        phase_nx = PH_MSB;
        idx_nx   = TOP;
      end
      PH_MSB: begin
        if (idx == '0) begin
          phase_nx = PH_LSB;
          idx_nx   = IDXW'(1);
        end else begin
          idx_nx = idx - IDXW'(1);
        end
      end
      PH_LSB: begin
        if (idx == TOP) phase_nx = PH_DONE;
        else            idx_nx   = idx + IDXW'(1);
      end
      default: phase_nx = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_WAIT;
      idx     <= '0;
      cfg_sgl <= 1'b0;
      cfg_odd <= 1'b0;
    end else begin
      phase <= phase_nx;
      idx   <= idx_nx;
      if (sgl_en) cfg_sgl <= di;
      if (odd_en) cfg_odd <= di;
    end
  end
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar #(
  parameter int RES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_en,
  input  logic [$clog2(RES)-1:0] idx,
  input  logic                   cmp,
  output logic [RES-1:0]         result,
  output logic [RES-1:0]         trial
);
  localparam int IDXW = $clog2(RES);

  logic [RES-1:0] result_nx;

  for (genvar gi = 0; gi < RES; gi++) begin : g_trial
    assign trial[gi] = step_en &
                       ((IDXW'(gi) > idx) ? result[gi] : (IDXW'(gi) == idx));
  end

  always_comb begin
    result_nx = result;
    if (step_en) result_nx[idx] = cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= result_nx;
  end
endmodule

// File: rtl/sadc_dout.sv
module sadc_dout
  import sadc_pkg::*;
#(
  parameter int RES = 8
) (
  input  phase_t                 phase,
  input  logic [$clog2(RES)-1:0] idx,
  input  logic                   cmp,
  input  logic [RES-1:0]         result,
  output logic                   do_data,
  output logic                   do_oe
);
  always_comb begin
    do_oe   = (phase == PH_SETTLE) || (phase == PH_MSB) || (phase == PH_LSB);
    do_data = 1'b0;
    if (phase == PH_MSB)      do_data = cmp;
    else if (phase == PH_LSB) do_data = result[idx];
  end
endmodule

// File: rtl/sadc_core.sv
module sadc_core
  import sadc_pkg::*;
#(
  parameter int RES = 8
) (
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           di,
  input  logic           cmp_gt,
  output logic [RES-1:0] trial_code,
  output logic           sel_single,
  output logic           sel_odd,
  output logic           do_data,
  output logic           do_oe
);
  localparam int IDXW = $clog2(RES);

  logic            rst_n;
  phase_t          phase;
  logic [IDXW-1:0] idx;
  logic [RES-1:0]  result;
  logic            step_en;

  assign rst_n   = ~cs_n;
  assign step_en = (phase == PH_MSB);

  sadc_ctrl #(.RES(RES)) u_ctrl (
    .clk(sclk), .rst_n(rst_n), .di(di), .phase(phase), .idx(idx),
    .cfg_sgl(sel_single), .cfg_odd(sel_odd)
  );

  sadc_sar #(.RES(RES)) u_sar (
    .clk(sclk), .rst_n(rst_n), .step_en(step_en), .idx(idx), .cmp(cmp_gt),
    .result(result), .trial(trial_code)
  );

  sadc_dout #(.RES(RES)) u_dout (
    .phase(phase), .idx(idx), .cmp(cmp_gt), .result(result),
    .do_data(do_data), .do_oe(do_oe)
  );
endmodule

// File: rtl/sadc_core_chk.sv
module sadc_core_chk #(
  parameter int RES = 8
) (
  input logic           sclk,
  input logic           cs_n,
  input logic [RES-1:0] trial_code,
  input logic           sel_single,
  input logic           sel_odd,
  input logic           do_data,
  input logic           do_oe
);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  AST_CLEAR_WHEN_DESELECTED: assert property (@(negedge sclk)
    cs_n |-> (!do_oe && trial_code == '0 && !sel_single && !sel_odd)); // R1

  AST_SETTLE_DRIVES_LOW: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(do_oe) |-> !do_data); // R4

  AST_FIRST_TRIAL_MSB: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(do_oe) |=> trial_code == MSB_ONLY); // R5

  AST_NO_TRIAL_WHEN_IDLE: assert property (@(posedge sclk) disable iff (cs_n)
    !do_oe |-> trial_code == '0); // R5

  AST_SEL_STABLE_IN_CONV: assert property (@(posedge sclk) disable iff (cs_n)
    (do_oe && $past(do_oe)) |-> ($stable(sel_single) && $stable(sel_odd))); // R8

  AST_OE_STAYS_OFF: assert property (@(posedge sclk) disable iff (cs_n)
    $fell(do_oe) |=> !do_oe); // R9
endmodule

bind sadc_core sadc_core_chk #(.RES(RES)) u_chk (
  .sclk(sclk), .cs_n(cs_n), .trial_code(trial_code), .sel_single(sel_single),
  .sel_odd(sel_odd), .do_data(do_data), .do_oe(do_oe)
);

// File: tb/sadc_core_tb.sv
`timescale 1ns/1ps
module sadc_core_tb;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       di = 1'b0;
  logic       cmp_gt;
  logic [7:0] trial_code;
  logic       sel_single, sel_odd, do_data, do_oe;

  int checks = 0;
  int failures = 0;
  int ch0_v = 0;
  int ch1_v = 0;
  bit done = 0;

  always #10 sclk = ~sclk;

  sadc_core u_dut (
    .sclk(sclk), .cs_n(cs_n), .di(di), .cmp_gt(cmp_gt), .trial_code(trial_code),
    .sel_single(sel_single), .sel_odd(sel_odd), .do_data(do_data), .do_oe(do_oe)
  );

  // analog model: selected positive minus negative, compared with the ladder
  always_comb begin
    int p, n;
    if (sel_single) begin
      p = sel_odd ? ch1_v : ch0_v;
      n = 0;
    end else begin
      p = sel_odd ? ch1_v : ch0_v;
      n = sel_odd ? ch0_v : ch1_v;
    end
    cmp_gt = ((p - n) >= int'(trial_code));
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int expect_result(input bit sgl, input bit odd);
    int d;
    if (sgl) d = odd ? ch1_v : ch0_v;
    else     d = odd ? (ch1_v - ch0_v) : (ch0_v - ch1_v);
    if (d < 0) d = 0;
    if (d > 255) d = 255;
    return d;
  endfunction

  task automatic check_slot(input int n, input bit sgl, input bit odd, input int res);
    if (n < 2) begin
      chk("R2 oe before settle", do_oe, 0);
      chk("R5 trial before search", trial_code, 0);
      if (n < 0) begin
        chk("R2 sel before start", {sel_single, sel_odd}, 0);
      end
    end else begin
      chk("R3 sel_single", sel_single, sgl);
      chk("R3 sel_odd", sel_odd, odd);
      if (n == 2) begin
        chk("R4 settle oe", do_oe, 1);
        chk("R4 settle low", do_data, 0);
      end else if (n <= 10) begin
        int k = 10 - n;
        int tr = (res & ~((2 << k) - 1)) | (1 << k);
        chk("R6 msb oe", do_oe, 1);
        chk("R6 msb-first bit", do_data, (res >> k) & 1);
        chk("R5 trial code", trial_code, tr);
      end else if (n <= 17) begin
        chk("R7 lsb oe", do_oe, 1);
        chk("R7 lsb-first bit", do_data, (res >> (n - 10)) & 1);
        chk("R5 trial off", trial_code, 0);
      end else begin
        chk("R9 oe after frame", do_oe, 0);
        chk("R9 trial after frame", trial_code, 0);
      end
    end
  endtask

  // One frame. lead zeros before start, junk on di afterwards (R8).
  // abort_n >= 0 raises cs_n after that slot (R1).
  task automatic frame(input int lead, input bit sgl, input bit odd,
                       input int c0, input int c1, input int tail, input int abort_n);
    int n = -1;
    int res;
    bit bits[$];
    ch0_v = c0;
    ch1_v = c1;
    res = expect_result(sgl, odd);
    for (int i = 0; i < lead; i++) bits.push_back(1'b0);
    bits.push_back(1'b1);
    bits.push_back(sgl);
    bits.push_back(odd);
    for (int i = 0; i < 18 + tail; i++) bits.push_back((i % 3) != 1);
    @(negedge sclk);
    #2 cs_n = 1'b0;
    foreach (bits[i]) begin
      #2 di = bits[i];
      @(posedge sclk);
      if (n < 0) begin
        if (bits[i]) n = 0;
      end else n++;
      @(negedge sclk);
      check_slot(n, sgl, odd, res);
      if (abort_n >= 0 && n == abort_n) begin
        #2 cs_n = 1'b1;
        #1;
        chk("R1 abort oe", do_oe, 0);
        chk("R1 abort trial", trial_code, 0);
        chk("R1 abort sel", {sel_single, sel_odd}, 0);
        return;
      end
    end
    #2 cs_n = 1'b1;
    di = 1'b0;
    #1;
    chk("R11 deselect clears oe", do_oe, 0);
    chk("R11 deselect clears sel", {sel_single, sel_odd}, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge sclk);
    chk("R1 reset oe", do_oe, 0);
    chk("R1 reset trial", trial_code, 0);
    chk("R1 reset sel", {sel_single, sel_odd}, 0);
    frame(0, 1'b0, 1'b0, 200, 55, 0, -1);   // diff 145
    frame(3, 1'b1, 1'b1, 7, 8'hAA, 4, -1);  // single ch1, leading zeros R2
    frame(1, 1'b0, 1'b1, 100, 40, 2, -1);   // ch1 below ch0: zero R10
    frame(0, 1'b1, 1'b0, 255, 3, 5, -1);    // full scale
    frame(2, 1'b1, 1'b0, 0, 90, 0, -1);     // zero code
    frame(0, 1'b0, 1'b0, 180, 20, 0, 6);    // abort mid-search R1
    frame(0, 1'b1, 1'b0, 1, 0, 1, -1);      // fresh frame after abort R11
    frame(4, 1'b0, 1'b1, 30, 158, 3, -1);   // diff reversed, 128
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule